// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is a hardware SPI master that turns short host requests into complete serial NOR flash command sequences. The host presents an operation code, a 24-bit flash address and a byte count on a valid/ready handshake. The block then drives chip select, clock and data lines until the whole sequence is finished, and it signals the end with a one-cycle done pulse. Bytes read from the flash come out as a stream of valid strobes. Bytes to be programmed are taken from a data input, and the block acknowledges each one as it is consumed.

Five operations are supported: a device identification probe, a read, a byte-wise program, a sector erase and write-disable. Before any command that changes the array or the status register, the block sends write-enable and reads the status register back, and it repeats this pair until the write-enable latch is set. Before an operation starts, and after each program or erase frame, the block polls the status register in separate frames until the busy flag clears. The probe also clears all block-protection bits. The serial link runs in SPI mode 0, and a parameter sets the clock divider.

Top module: `spi_nor_seq`

## Requirements
- R1: After reset, chip select is high, SCK is low, req_ready_o is high, and done_o, rd_valid_o and wr_ack_o are low.
- R2: Every addressed frame sends the opcode first, then the 24-bit address as three bytes, most significant byte first, all inside one chip-select low period.
- R3: Operation code 1 (read) sends opcode 0x03 and the address, then returns req_len_i bytes from consecutive addresses on rd_data_o, one per rd_valid_o strobe. During every receive phase MOSI carries 0xFF.
- R4: Before probe, read, program or erase traffic, status (opcode 0x05) is read in separate frames until bit 0 (busy) is 0. No other command frame is issued while the device reports busy.
- R5: Each write-enable frame (opcode 0x06) is followed by a status read. The pair repeats until status bit 1 (write-enable latch) reads 1.
- R6: Operation code 2 (program) sends one frame per byte. Each frame carries opcode 0x02, the address and exactly one data byte, and is preceded by its own write-enable. After each frame the block polls busy, then increments the address. wr_ack_o pulses once per byte consumed.
- R7: A program request with req_len_i of 0, or any operation code above 4, produces no flash traffic. It completes with done_o and err_o high together.
- R8: Operation code 3 (erase) sends opcode 0x20 with the address rounded down to a 2^SECT_W byte boundary (low SECT_W bits cleared). It waits for busy to clear afterwards.
- R9: Operation code 0 (probe) sends 0x90 with three zero address bytes and reads two bytes. It presents id_o as {first byte, second byte}. It then write-enables and writes status (opcode 0x01) with 0x00 to clear the protection bits 2 to 5.
- R10: Operation code 4 (write disable) issues exactly one frame with opcode 0x04 and no status polling.
- R11: SCK idles low while chip select is high (mode 0). Chip select stays high for at least two system clocks between frames.
- R12: done_o is a single-cycle pulse that coincides with req_ready_o high. req_ready_o is low while a sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Idle, request accepted when valid |
| req_op_i | input | 3 | 0 probe, 1 read, 2 program, 3 erase, 4 write disable |
| req_addr_i | input | 24 | Flash byte address |
| req_len_i | input | LEN_W | Byte count for read and program |
| wr_data_i | input | 8 | Current byte to program |
| wr_ack_o | output | 1 | Pulse: current program byte consumed |
| rd_data_o | output | 8 | Read data byte |
| rd_valid_o | output | 1 | Read data strobe |
| done_o | output | 1 | Sequence finished pulse |
| err_o | output | 1 | Request rejected, valid with done_o |
| id_o | output | 16 | Last probe result, first byte in upper half |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |
| spi_cs_no | output | 1 | Active-low chip select |

## Verification
Reads come from a table of start addresses and lengths. Different upper address bytes catch a byte-order slip in the address phase, and lengths of one and several bytes catch an off-by-one at the end of the receive phase. Programs with several bytes show that each byte gets its own frame and its own write-enable, which a single burst frame would not. A flash model that ignores the first write-enables, and one that is held busy before a read starts, separate true status-driven polling from a fixed count. Erase addresses with nonzero low bits, zero-length programs and an undefined operation code cover the alignment and rejection paths.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

  typedef enum logic [2:0] {
    OP_PROBE = 3'd0,
    OP_READ  = 3'd1,
    OP_PROG  = 3'd2,
    OP_ERASE = 3'd3,
    OP_WRDI  = 3'd4
  } host_op_e;

  typedef enum logic [2:0] {
    FR_RDSR, FR_WREN, FR_WRDI, FR_WRSR, FR_ERASE, FR_PROG, FR_READ, FR_ID
  } frame_e;

  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_WRDI  = 8'h04;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] CMD_WRSR  = 8'h01;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_ID    = 8'h90;

  function automatic logic [7:0] frame_opcode(frame_e k);
    case (k)
      FR_RDSR:  return CMD_RDSR;
      FR_WREN:  return CMD_WREN;
      FR_WRDI:  return CMD_WRDI;
      FR_WRSR:  return CMD_WRSR;
      FR_ERASE: return CMD_ERASE;
      FR_PROG:  return CMD_PROG;
      FR_READ:  return CMD_READ;
      default:  return CMD_ID;
    endcase
  endfunction

  // bytes driven by the master before any receive phase
  function automatic logic [2:0] frame_hdr(frame_e k);
    case (k)
      FR_WRSR:  return 3'd2;
      FR_ERASE: return 3'd4;
      FR_PROG:  return 3'd5;
      FR_READ:  return 3'd4;
      FR_ID:    return 3'd4;
      default:  return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/spi_nor_shifter.sv
module spi_nor_shifter #(
  parameter int DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic          busy_q, sck_q, done_q;
  logic [7:0]    tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= 8'hFF;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        tx_q   <= tx_i;
        busy_q <= 1'b1;
        sck_q  <= 1'b0;
        div_q  <= '0;
        bit_q  <= 3'd7;
      end else if (busy_q) begin
        if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd0) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q - 3'd1;
              tx_q  <= {tx_q[6:0], 1'b1};
            end
          end
        end else begin
          div_q <= div_q + DW'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];

endmodule

// File: rtl/spi_nor_frame.sv
module spi_nor_frame
  import spi_nor_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int DIV    = 2,
  parameter int CS_GAP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  frame_e           kind_i,
  input  logic [23:0]      addr_i,
  input  logic [LEN_W-1:0] rd_len_i,
  input  logic [7:0]       wr_byte_i,
  output logic             done_o,
  output logic             rx_vld_o,
  output logic [7:0]       rx_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             cs_no
);
  localparam int IDX_W = LEN_W + 1;
  localparam int GW    = $clog2(CS_GAP + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);

  typedef enum logic [1:0] {F_IDLE, F_SEND, F_WAIT, F_GAP} fst_e;

  fst_e             st_q;
  frame_e           kind_q;
  logic [23:0]      addr_q;
  logic [IDX_W-1:0] idx_q, hdr_q, tot_q, rd_cnt;
  logic [GW-1:0]    gap_q;
  logic             cs_n_q, sh_start_q, done_q, rx_vld_q, sh_done;
  logic [7:0]       tx_byte;

  always_comb begin
    case (kind_i)
      FR_RDSR: rd_cnt = IDX_W'(1);
      FR_ID:   rd_cnt = IDX_W'(2);
      FR_READ: rd_cnt = IDX_W'(rd_len_i);
      default: rd_cnt = '0;
    endcase
  end

  always_comb begin
    tx_byte = 8'hFF;
    if (idx_q == '0)                 tx_byte = frame_opcode(kind_q);
    else if (idx_q < hdr_q) begin
      if (kind_q == FR_WRSR)          tx_byte = 8'h00;
      else if (idx_q == IDX_W'(1))    tx_byte = addr_q[23:16];
      else if (idx_q == IDX_W'(2))    tx_byte = addr_q[15:8];
      else if (idx_q == IDX_W'(3))    tx_byte = addr_q[7:0];
      else                            tx_byte = wr_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= F_IDLE;
      kind_q     <= FR_RDSR;
      addr_q     <= '0;
      idx_q      <= '0;
      hdr_q      <= '0;
      tot_q      <= '0;
      gap_q      <= '0;
      cs_n_q     <= 1'b1;
      sh_start_q <= 1'b0;
      done_q     <= 1'b0;
      rx_vld_q   <= 1'b0;
    end else begin
      sh_start_q <= 1'b0;
      done_q     <= 1'b0;
      rx_vld_q   <= 1'b0;
      case (st_q)
        F_IDLE: if (start_i) begin
          kind_q <= kind_i;
          addr_q <= addr_i;
          hdr_q  <= IDX_W'(frame_hdr(kind_i));
          tot_q  <= IDX_W'(frame_hdr(kind_i)) + rd_cnt;
          idx_q  <= '0;
          cs_n_q <= 1'b0;
          st_q   <= F_SEND;
        end
        F_SEND: begin
          sh_start_q <= 1'b1;
          st_q       <= F_WAIT;
        end
        F_WAIT: if (sh_done) begin
          if (idx_q >= hdr_q) rx_vld_q <= 1'b1;
          if (idx_q == tot_q - IDX_W'(1)) begin
            cs_n_q <= 1'b1;
            gap_q  <= '0;
            st_q   <= F_GAP;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            st_q  <= F_SEND;
          end
        end
        default: begin
          if (gap_q == GAP_LAST) begin
            done_q <= 1'b1;
            st_q   <= F_IDLE;
          end else begin
            gap_q <= gap_q + GW'(1);
          end
        end
      endcase
    end
  end

  spi_nor_shifter #(.DIV(DIV)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start_q),
    .tx_i    (tx_byte),
    .done_o  (sh_done),
    .rx_o    (rx_o),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i)
  );

  assign done_o   = done_q;
  assign rx_vld_o = rx_vld_q;
  assign cs_no    = cs_n_q;

endmodule

// File: rtl/spi_nor_seq.sv
module spi_nor_seq
  import spi_nor_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 2,
  parameter int SECT_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [2:0]       req_op_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wr_data_i,
  output logic             wr_ack_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             err_o,
  output logic [15:0]      id_o,
  output logic             spi_sck_o,
  output logic             spi_mosi_o,
  input  logic             spi_miso_i,
  output logic             spi_cs_no
);
  typedef enum logic [2:0] {
    T_IDLE, T_POLL0, T_WEN, T_WENCHK, T_MAIN, T_POLL1, T_WRSR, T_DONE
  } tst_e;

  tst_e             st_q;
  host_op_e         op_q;
  logic [23:0]      addr_q, fr_addr;
  logic [LEN_W-1:0] len_q;
  logic [1:0]       stat_q;
  logic [15:0]      id_q;
  logic             fr_busy_q, fr_start_q, done_q, err_q, err_pend_q, wr_ack_q;
  logic             fr_done, fr_rx_vld;
  logic [7:0]       fr_rx;
  frame_e           fr_kind;

  always_comb begin
    case (st_q)
      T_WEN:  fr_kind = FR_WREN;
      T_WRSR: fr_kind = FR_WRSR;
      T_MAIN: begin
        case (op_q)
          OP_PROBE: fr_kind = FR_ID;
          OP_READ:  fr_kind = FR_READ;
          OP_PROG:  fr_kind = FR_PROG;
          OP_ERASE: fr_kind = FR_ERASE;
          default:  fr_kind = FR_WRDI;
        endcase
      end
      default: fr_kind = FR_RDSR;
    endcase
  end

  always_comb begin
    if (op_q == OP_PROBE)      fr_addr = '0;
    else if (op_q == OP_ERASE) fr_addr = {addr_q[23:SECT_W], {SECT_W{1'b0}}};
    else                       fr_addr = addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= T_IDLE;
      op_q       <= OP_WRDI;
      addr_q     <= '0;
      len_q      <= '0;
      stat_q     <= '0;
      id_q       <= '0;
      fr_busy_q  <= 1'b0;
      fr_start_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_pend_q <= 1'b0;
      wr_ack_q   <= 1'b0;
    end else begin
      fr_start_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      wr_ack_q   <= 1'b0;
      if (fr_rx_vld) begin
        stat_q <= fr_rx[1:0];
        if (st_q == T_MAIN && op_q == OP_PROBE) id_q <= {id_q[7:0], fr_rx};
      end
      case (st_q)
        T_IDLE: if (req_valid_i) begin
          op_q   <= host_op_e'(req_op_i);
          addr_q <= req_addr_i;
          len_q  <= req_len_i;
          case (req_op_i)
            3'd0, 3'd1, 3'd3: st_q <= T_POLL0;
            3'd2: begin
              if (req_len_i == '0) begin
                err_pend_q <= 1'b1;
                st_q       <= T_DONE;
              end else begin
                st_q <= T_POLL0;
              end
            end
            3'd4: st_q <= T_MAIN;
            default: begin
              err_pend_q <= 1'b1;
              st_q       <= T_DONE;
            end
          endcase
        end
        T_DONE: begin
          done_q     <= 1'b1;
          err_q      <= err_pend_q;
          err_pend_q <= 1'b0;
          st_q       <= T_IDLE;
        end
        default: begin
          if (!fr_busy_q) begin
            fr_start_q <= 1'b1;
            fr_busy_q  <= 1'b1;
          end else if (fr_done) begin
            fr_busy_q <= 1'b0;
            case (st_q)
              T_POLL0: if (!stat_q[0])
                st_q <= (op_q == OP_PROBE || op_q == OP_READ) ? T_MAIN : T_WEN;
              T_WEN: st_q <= T_WENCHK;
              T_WENCHK: if (stat_q[1])
                st_q <= (op_q == OP_PROBE) ? T_WRSR : T_MAIN;
              else
                st_q <= T_WEN;
              T_MAIN: begin
                if (op_q == OP_PROG) begin
                  wr_ack_q <= 1'b1;
                  addr_q   <= addr_q + 24'd1;
                  len_q    <= len_q - LEN_W'(1);
                end
                st_q <= (op_q == OP_READ || op_q == OP_WRDI) ? T_DONE : T_POLL1;
              end
              T_POLL1: if (!stat_q[0]) begin
                if (op_q == OP_PROBE) st_q <= T_WEN;
                else if (op_q == OP_PROG && len_q != '0) st_q <= T_WEN;
                else st_q <= T_DONE;
              end
              default: st_q <= T_DONE;
            endcase
          end
        end
      endcase
    end
  end

  spi_nor_frame #(.LEN_W(LEN_W), .DIV(CLK_DIV), .CS_GAP(CS_GAP)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (fr_start_q),
    .kind_i    (fr_kind),
    .addr_i    (fr_addr),
    .rd_len_i  (len_q),
    .wr_byte_i (wr_data_i),
    .done_o    (fr_done),
    .rx_vld_o  (fr_rx_vld),
    .rx_o      (fr_rx),
    .sck_o     (spi_sck_o),
    .mosi_o    (spi_mosi_o),
    .miso_i    (spi_miso_i),
    .cs_no     (spi_cs_no)
  );

  assign req_ready_o = (st_q == T_IDLE);
  assign rd_valid_o  = fr_rx_vld && st_q == T_MAIN && op_q == OP_READ;
  assign rd_data_o   = fr_rx;
  assign wr_ack_o    = wr_ack_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign id_o        = id_q;

endmodule

// File: rtl/spi_nor_seq_chk.sv
module spi_nor_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic done_o,
  input logic err_o,
  input logic rd_valid_o,
  input logic wr_ack_o,
  input logic spi_sck_o,
  input logic spi_cs_no
);
  // R11
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);
  // R11
  cs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |=> spi_cs_no);
  // R12
  done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  err_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R3
  rd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !req_ready_o);
  // R6
  ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack_o |-> !req_ready_o);
endmodule

bind spi_nor_seq spi_nor_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .rd_valid_o  (rd_valid_o),
  .wr_ack_o    (wr_ack_o),
  .spi_sck_o   (spi_sck_o),
  .spi_cs_no   (spi_cs_no)
);

// File: tb/test_spi_nor_seq.sv
`timescale 1ns/1ps
module test_spi_nor_seq;
  localparam int LEN_W = 16;
  localparam int BUSY_CYC = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] wr_data, rd_data;
  logic wr_ack, rd_valid, done, err;
  logic [15:0] id;
  logic sck, mosi, miso = 1'b0, cs_n;

  always #2.5 clk = ~clk;

  spi_nor_seq i_spi_nor_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_len_i(req_len),
    .wr_data_i(wr_data), .wr_ack_o(wr_ack), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .done_o(done), .err_o(err), .id_o(id),
    .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso), .spi_cs_no(cs_n)
  );

  // ---------------- flash model ----------------
  int cyc = 0;
  int force_until = 0;
  int ign_until = 0;
  logic [7:0] mem [256];
  logic [7:0] fb [8];
  logic [7:0] sh_in, osh, ob;
  int bitc, nb;
  int busy_until = 0;
  logic wel = 1'b0;
  logic [3:0] bp = 4'hF;
  logic cs_prev = 1'b1, sck_prev = 1'b0, busy_at_start = 1'b0;
  int frames = 0, rdsr_cnt = 0, wren_cnt = 0, wrdi_cnt = 0, prog_cnt = 0, erase_cnt = 0;
  int bad_len = 0, nowel = 0, busy_viol = 0, filler_err = 0, wrsr_cnt = 0;
  logic [23:0] rd_addr_seen = '0, er_addr_seen = '1, id_addr_seen = '1;
  logic [7:0] last_op = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  function automatic logic model_busy();
    return (cyc < busy_until) || (cyc < force_until);
  endfunction

  function automatic logic [7:0] resp(int n);
    logic [23:0] a;
    a = {fb[1], fb[2], fb[3]};
    if (fb[0] == 8'h05) return {2'b00, bp, wel, model_busy()};
    if (fb[0] == 8'h03 && n >= 4) return mem[8'(a + 24'(n - 4))];
    if (fb[0] == 8'h90 && n == 4) return 8'hBF;
    if (fb[0] == 8'h90 && n == 5) return 8'h8E;
    return 8'hFF;
  endfunction

  always @(sck or cs_n) begin
    if (cs_n !== cs_prev) begin
      if (!cs_n) begin
        bitc = 0; nb = 0; frames++;
        busy_at_start = model_busy();
        for (int i = 0; i < 8; i++) fb[i] = 8'h00;
      end else begin
        last_op = fb[0];
        if (busy_at_start && fb[0] != 8'h05) busy_viol++;
        case (fb[0])
          8'h05: rdsr_cnt++;
          8'h06: begin wren_cnt++; if (wren_cnt > ign_until) wel = 1'b1; end
          8'h04: begin wrdi_cnt++; wel = 1'b0; end
          8'h01: begin wrsr_cnt++; if (wel && nb == 2) bp = fb[1][5:2]; wel = 1'b0; end
          8'h02: begin
            prog_cnt++;
            if (nb != 5) bad_len++;
            if (wel) mem[fb[3]] = fb[4]; else nowel++;
            wel = 1'b0; busy_until = cyc + BUSY_CYC;
          end
          8'h20: begin
            erase_cnt++;
            er_addr_seen = {fb[1], fb[2], fb[3]};
            if (wel) for (int i = 0; i < 256; i++) mem[i] = 8'hFF; else nowel++;
            wel = 1'b0; busy_until = cyc + BUSY_CYC;
          end
          8'h03: rd_addr_seen = {fb[1], fb[2], fb[3]};
          8'h90: id_addr_seen = {fb[1], fb[2], fb[3]};
          default: ;
        endcase
      end
    end else if (!cs_n && sck && !sck_prev) begin
      sh_in = {sh_in[6:0], mosi};
      bitc++;
      if (bitc % 8 == 0) begin
        if (nb < 8) fb[nb] = sh_in;
        if (((fb[0] == 8'h03 || fb[0] == 8'h90) && nb >= 4) ||
            (fb[0] == 8'h05 && nb >= 1))
          if (sh_in != 8'hFF) filler_err++;
        nb++;
      end
    end else if (!cs_n && !sck && sck_prev) begin
      if (bitc % 8 == 0) begin
        ob = resp(nb); miso = ob[7]; osh = {ob[6:0], 1'b1};
      end else begin
        miso = osh[7]; osh = {osh[6:0], 1'b1};
      end
    end
    cs_prev = cs_n; sck_prev = sck;
  end

  // ---------------- monitors ----------------
  int hi_run = 0, min_hi = 1000, done_long = 0, ready_err = 0;
  logic seen_low = 1'b0, done_prev = 1'b0;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (cs_n) hi_run++;
    else begin
      if (seen_low && hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
      hi_run = 0; seen_low = 1'b1;
      if (req_ready) ready_err++;
    end
    if (done && done_prev) done_long++;
    done_prev = done;
  end

  // ---------------- host side ----------------
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [16];
  int wk, rk;
  logic last_err;
  assign wr_data = wbuf[wk[2:0]];

  int nchk = 0, nfail = 0;
  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] op, input logic [23:0] a, input int len);
    wk = 0; rk = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_len = LEN_W'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_valid && rk < 16) begin rbuf[rk] = rd_data; rk++; end
      if (wr_ack) wk++;
      if (done) begin last_err = err; break; end
    end
  endtask

  localparam int NRV = 4;
  localparam logic [31:0] RD_VEC [NRV] = '{
    {24'h00ABCD, 8'd4}, {24'h3C0001, 8'd1}, {24'h12FFF0, 8'd8}, {24'h800080, 8'd3}
  };

  initial begin
    logic timeout;
    int f0, w0, p0, r0;
    timeout = 1'b0;
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h00;
    fork
      begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(req_ready && !done && !rd_valid && !wr_ack, "R1 idle",
            {req_ready, done, rd_valid, wr_ack}, 4'b1000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        // R9 probe
        w0 = wrsr_cnt;
        do_req(3'd0, 24'h123456, 0);
        chk(id == 16'hBF8E, "R9 id", id, 16'hBF8E);
        chk(id_addr_seen == 24'h0, "R9 id address", id_addr_seen, 0);
        chk(bp == 4'h0 && wrsr_cnt == w0 + 1, "R9 protect cleared", bp, 0);

        // R3 R2 read table
        for (int v = 0; v < NRV; v++) begin
          logic [23:0] a; int n;
          a = RD_VEC[v][31:8]; n = int'(RD_VEC[v][7:0]);
          do_req(3'd1, a, n);
          chk(rd_addr_seen == a, "R2 address order", rd_addr_seen, a);
          chk(rk == n, "R3 byte count", rk, n);
          for (int i = 0; i < n; i++)
            chk(rbuf[i] == (8'(a + 24'(i)) ^ 8'h5A), "R3 read data", rbuf[i],
                8'(a + 24'(i)) ^ 8'h5A);
        end
        chk(filler_err == 0, "R3 filler 0xFF", filler_err, 0);

        // R6 program three bytes
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        p0 = prog_cnt; w0 = wren_cnt;
        do_req(3'd2, 24'h000040, 3);
        chk(prog_cnt == p0 + 3, "R6 one frame per byte", prog_cnt - p0, 3);
        chk(wren_cnt == w0 + 3, "R6 wren per byte", wren_cnt - w0, 3);
        chk(bad_len == 0 && nowel == 0, "R6 frame shape", bad_len + nowel, 0);
        chk(wk == 3, "R6 acks", wk, 3);
        chk(mem[8'h40] == 8'hA1 && mem[8'h41] == 8'hB2 && mem[8'h42] == 8'hC3,
            "R6 stored bytes", {mem[8'h40], mem[8'h41], mem[8'h42]}, 24'hA1B2C3);
        chk(!last_err, "R6 no error", last_err, 0);

        // R4 device busy before read
        force_until = cyc + 500; r0 = rdsr_cnt;
        do_req(3'd1, 24'h000041, 1);
        chk(rbuf[0] == 8'hB2, "R4 read after busy", rbuf[0], 8'hB2);
        chk(rdsr_cnt > r0 + 1, "R4 repeated polls", rdsr_cnt - r0, 2);
        chk(busy_viol == 0, "R4 no command while busy", busy_viol, 0);

        // R5 R8 erase with latch ignored twice
        ign_until = wren_cnt + 2; w0 = wren_cnt;
        do_req(3'd3, 24'h012345, 0);
        chk(wren_cnt == w0 + 3, "R5 wren retries", wren_cnt - w0, 3);
        chk(er_addr_seen == 24'h012000, "R8 aligned address", er_addr_seen, 24'h012000);
        chk(mem[8'h40] == 8'hFF && nowel == 0, "R8 erased", mem[8'h40], 8'hFF);
        chk(busy_viol == 0, "R4 busy after erase", busy_viol, 0);

        // R7 rejections
        f0 = frames;
        do_req(3'd2, 24'h000010, 0);
        chk(last_err == 1'b1, "R7 zero length err", last_err, 1);
        do_req(3'd6, 24'h000010, 2);
        chk(last_err == 1'b1, "R7 bad op err", last_err, 1);
        chk(frames == f0, "R7 no traffic", frames - f0, 0);

        // R10 write disable
        f0 = frames; w0 = wrdi_cnt;
        do_req(3'd4, 24'h0, 0);
        chk(frames == f0 + 1 && wrdi_cnt == w0 + 1 && last_op == 8'h04,
            "R10 single frame", frames - f0, 1);
        chk(!last_err, "R10 no error", last_err, 0);

        // R11 R12 link and handshake monitors
        chk(min_hi >= 2, "R11 cs high time", min_hi, 2);
        chk(done_long == 0, "R12 done pulse", done_long, 0);
        chk(ready_err == 0, "R12 ready low while busy", ready_err, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule